// File: doc/BRIEF.md
# USB2 Root Port Status Controller

This block holds the status and control word of a single USB2 root hub port and sequences that port through its life. A raw connect input shows whether a device is present. On attach, the block marks the port connected with the link in the Polling state. On detach, it drops the port back to the disconnected state. Software starts a port reset by setting the reset bit. The block then holds the reset for a fixed number of clock cycles and finishes it by enabling the port and moving the link to U0.

Two change flags are kept: connect change and reset change. Software clears them by writing ones to them. Whenever the OR of the change flags goes from 0 to 1, the block emits a one-cycle event strobe. The strobe carries the port number, so software can tell which port needs service. While any change flag is still set, no further event is raised. Clearing all change flags re-arms the event.

Top module: `root_port_status`

## Requirements
- R1: After reset the status word reads 0x0000_00A0. This means not connected, not enabled, no reset, no change flags, and the link field (bits [8:5]) at 5, the disconnected state. No event is raised.
- R2: When the connect input rises, bit 0 (connected) and bit 16 (connect change) read 1 from the next cycle on. Bit 1 (enabled) and bit 4 (reset) read 0, and the link field reads 7 (Polling).
- R3: When the connect input falls on a connected port, bit 0 reads 0 and bit 16 reads 1 from the next cycle on. Bits 1 and 4 read 0, the link field reads 5, and bit 17 (reset change) keeps its value.
- R4: A register write with bit 4 set, on a connected port not already in reset, makes bit 4 read 1 for exactly RESET_CYCLES cycles, starting the cycle after the write.
- R5: When the reset phase ends, bit 17 and bit 1 are set, bit 4 is cleared and the link field reads 0 (U0), all in the same cycle.
- R6: The event strobe is high for one cycle, one cycle after a change flag is set, and only if no change flag was set before. No event is raised while any change flag is already set.
- R7: Bits 16 and 17 are write-1-to-clear. Writing 0 to them leaves them unchanged, and the other bits ignore writes. After all change flags are clear, the next change raises a new event.
- R8: A detach during the reset phase ends the reset and clears bits 1 and 4. Bit 17 is not set, and no completion follows later.
- R9: A write of bit 4 is ignored while no device is connected and while a reset is already running.
- R10: The event carries the parameter PORT_ID on its port-number output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| connIn | input | 1 | Raw device-present indication |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 32 | Write data (bit 4 starts reset, bits 16/17 clear change flags) |
| regRdData | output | 32 | Current status word |
| evtValid | output | 1 | Port status change event strobe |
| evtPort | output | PORT_W | Port number carried by the event |

## Verification
The main sequencing is exercised with four input patterns:
- an attach followed by a full reset, with the connect change left pending, which shows that the reset change raises no second event;
- clearing the change flags one at a time, which separates the all-clear re-arm from a partial clear;
- a detach on an enabled port, which shows the detach state values and a fresh event;
- a detach in the middle of a reset, which tells an aborted reset apart from a completed one.

Reset writes while disconnected and during a running reset show that the reset timing stays fixed. A scoreboard compares every event strobe against the cycle and port number the bench predicts.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int REG_W      = 32;
  localparam int BIT_CONN   = 0;
  localparam int BIT_EN     = 1;
  localparam int BIT_RST    = 4;
  localparam int LINK_LSB   = 5;
  localparam int LINK_W     = 4;
  localparam int BIT_CCHG   = 16;
  localparam int BIT_RCHG   = 17;
  localparam logic [LINK_W-1:0] LINK_U0    = 4'd0;
  localparam logic [LINK_W-1:0] LINK_RXDET = 4'd5;
  localparam logic [LINK_W-1:0] LINK_POLL  = 4'd7;

  typedef struct packed {
    logic attach;
    logic detach;
    logic startRst;
    logic rstDone;
    logic clrConnChg;
    logic clrRstChg;
  } portStrobe_t;
endpackage

// File: rtl/rps_ctrl.sv
module rps_ctrl
  import rps_pkg::*;
#(
  parameter int RESET_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             connIn,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             connected,
  input  logic             resetting,
  output portStrobe_t      strobe
);
  localparam int CNT_W = (RESET_CYCLES > 1) ? $clog2(RESET_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES - 1);

  logic [CNT_W-1:0] rstCnt;
  logic detachNow;

  assign detachNow = ~connIn & connected;

  always_comb begin
    strobe            = '0;
    strobe.attach     = connIn & ~connected;
    strobe.detach     = detachNow;
    strobe.startRst   = regWr & regWrData[BIT_RST] & connected & ~resetting & ~detachNow;
    strobe.rstDone    = resetting & (rstCnt == '0) & ~detachNow;
    strobe.clrConnChg = regWr & regWrData[BIT_CCHG];
    strobe.clrRstChg  = regWr & regWrData[BIT_RCHG];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (strobe.startRst) begin
      rstCnt <= CNT_LOAD;
    end else if (resetting && rstCnt != '0) begin
      rstCnt <= rstCnt - 1'b1;
    end
  end

  // R9
  start_needs_conn_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startRst |-> (connected && !resetting));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startRst |=> (rstCnt == CNT_LOAD));
endmodule

// File: rtl/rps_dp.sv
module rps_dp
  import rps_pkg::*;
#(
  parameter int PORT_W  = 4,
  parameter int PORT_ID = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  output logic              connected,
  output logic              resetting,
  output logic [REG_W-1:0]  regRdData,
  output logic              evtValid,
  output logic [PORT_W-1:0] evtPort
);
  logic              enabled;
  logic [LINK_W-1:0] linkState;
  logic              connChg;
  logic              rstChg;
  logic              changePrev;
  logic              changeAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      connected <= 1'b0;
      enabled   <= 1'b0;
      resetting <= 1'b0;
      linkState <= LINK_RXDET;
    end else if (strobe.detach) begin
      connected <= 1'b0;
      enabled   <= 1'b0;
      resetting <= 1'b0;
      linkState <= LINK_RXDET;
    end else if (strobe.attach) begin
      connected <= 1'b1;
      enabled   <= 1'b0;
      resetting <= 1'b0;
      linkState <= LINK_POLL;
    end else if (strobe.rstDone) begin
      resetting <= 1'b0;
      enabled   <= 1'b1;
      linkState <= LINK_U0;
    end else if (strobe.startRst) begin
      resetting <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      connChg    <= 1'b0;
      rstChg     <= 1'b0;
      changePrev <= 1'b0;
    end else begin
      if (strobe.attach || strobe.detach) connChg <= 1'b1;
      else if (strobe.clrConnChg)         connChg <= 1'b0;
      if (strobe.rstDone)                 rstChg <= 1'b1;
      else if (strobe.clrRstChg)          rstChg <= 1'b0;
      changePrev <= changeAny;
    end
  end

  assign changeAny = connChg | rstChg;
  assign evtValid  = changeAny & ~changePrev;
  assign evtPort   = PORT_W'(PORT_ID);

  always_comb begin
    regRdData                        = '0;
    regRdData[BIT_CONN]              = connected;
    regRdData[BIT_EN]                = enabled;
    regRdData[BIT_RST]               = resetting;
    regRdData[LINK_LSB +: LINK_W]    = linkState;
    regRdData[BIT_CCHG]              = connChg;
    regRdData[BIT_RCHG]              = rstChg;
  end

  // R9
  reset_only_when_conn_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetting) |-> $past(connected));

  // R5
  reset_done_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(resetting) && connected) |-> (rstChg && enabled && linkState == LINK_U0));

  // R3
  detach_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(connected) |-> (connChg && !enabled && !resetting && linkState == LINK_RXDET));

  // R8
  enabled_needs_conn_chk: assert property (@(posedge clk) disable iff (!rstN)
    enabled |-> connected);

  // R6
  single_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid);
endmodule

// File: rtl/root_port_status.sv
module root_port_status
  import rps_pkg::*;
#(
  parameter int RESET_CYCLES = 8,
  parameter int PORT_W       = 4,
  parameter int PORT_ID      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              connIn,
  input  logic              regWr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              evtValid,
  output logic [PORT_W-1:0] evtPort
);
  portStrobe_t strobe;
  logic connected;
  logic resetting;

  rps_ctrl #(.RESET_CYCLES(RESET_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .connIn    (connIn),
    .regWr     (regWr),
    .regWrData (regWrData),
    .connected (connected),
    .resetting (resetting),
    .strobe    (strobe)
  );

  rps_dp #(.PORT_W(PORT_W), .PORT_ID(PORT_ID)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .connected (connected),
    .resetting (resetting),
    .regRdData (regRdData),
    .evtValid  (evtValid),
    .evtPort   (evtPort)
  );
endmodule

// File: tb/root_port_status_tb.sv
module root_port_status_tb;
  localparam int RC  = 8;
  localparam int PW  = 4;
  localparam int PID = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic connIn = 1'b0;
  logic regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic evtValid;
  logic [PW-1:0] evtPort;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int expCyc[$];
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  root_port_status #(.RESET_CYCLES(RC), .PORT_W(PW), .PORT_ID(PID)) u_dut (
    .clk(clk), .rstN(rstN), .connIn(connIn), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtValid(evtValid), .evtPort(evtPort)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [31:0] d);
    regWr = 1'b1; regWrData = d;
    tick();
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic expectEvt();
    expCyc.push_back(cyc + 1);
  endtask

  // Monitor: event scoreboard (R6, R10)
  always @(negedge clk) begin
    if (rstN && evtValid && !done) begin
      checks++;
      if (expCyc.size() == 0) begin
        fails++;
        $display("FAIL R6: unexpected event at cycle %0d expected none", cyc);
      end else begin
        int e;
        e = expCyc.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R6: event at cycle %0d expected %0d", cyc, e);
        end
      end
      checks++;
      if (evtPort !== PW'(PID)) begin
        fails++;
        $display("FAIL R10: port %0d expected %0d", evtPort, PID);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1 reset state", regRdData, 32'h0000_00A0);
    chk("R1 no event", {31'b0, evtValid}, 32'h0);

    wrReg(32'h10);
    tick();
    chk("R9 reset write while disconnected", regRdData, 32'h0000_00A0);

    expectEvt();
    connIn = 1'b1;
    tick();
    chk("R2 attach", regRdData, 32'h0001_00E1);

    wrReg(32'h0);
    chk("R7 write zero keeps flags", regRdData, 32'h0001_00E1);

    wrReg(32'h10);
    chk("R4 reset bit set", regRdData, 32'h0001_00F1);
    for (int i = 1; i < RC; i++) begin
      if (i == 3) wrReg(32'h10);
      else tick();
      chk("R4/R9 reset still running", regRdData & 32'h10, 32'h10);
    end
    tick();
    chk("R5 reset completion", regRdData, 32'h0003_0003);

    wrReg(32'h0001_0000);
    chk("R7 partial clear", regRdData, 32'h0002_0003);
    wrReg(32'h0002_0000);
    chk("R7 all clear", regRdData, 32'h0000_0003);

    expectEvt();
    connIn = 1'b0;
    tick();
    chk("R3 detach enabled port", regRdData, 32'h0001_00A0);

    wrReg(32'h0001_0000);
    chk("R7 clear after detach", regRdData, 32'h0000_00A0);
    expectEvt();
    connIn = 1'b1;
    tick();
    chk("R2 second attach", regRdData, 32'h0001_00E1);
    wrReg(32'h0001_0000);
    wrReg(32'h10);
    chk("R4 second reset start", regRdData, 32'h0000_00F1);
    tick(); tick();
    expectEvt();
    connIn = 1'b0;
    tick();
    chk("R8 detach aborts reset", regRdData, 32'h0001_00A0);
    repeat (RC + 2) tick();
    chk("R8 no late completion", regRdData, 32'h0001_00A0);

    tick();
    checks++;
    if (expCyc.size() != 0) begin
      fails++;
      $display("FAIL R6: %0d events missing expected 0", expCyc.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule